// File: doc/BRIEF.md
# Dithered Pulse-Swallow Clock Divider

This block takes a fast source clock and produces a slower gated clock. It does not count to a terminal value. Instead, it lets through a chosen fraction of the source pulses and swallows the rest. An 8-bit divide code sets that fraction: out of every 256 source pulses, code+1 are passed. Code 0x00 stops the output. When the code has the form 2^k−1, the output edges are evenly spaced. Any other code still gives the right average rate, because the spacing between passed pulses alternates between two neighbouring values.

An 8-bit phase accumulator makes the pass/swallow decision. It adds code+1 every source cycle, and a pulse is passed whenever the sum carries past 256. A per-mode minimum spacing can lower the output rate further. The pass decision feeds a gate enable that is registered on the falling source edge, so the output clock has no glitches.

Software writes a 32-bit configuration word into a shadow copy. The word holds a normal-mode code, a low-power code and two minimum-spacing fields. The shadow copy is applied only after a keyed write to a separate commit address, and only at the next accumulator wrap. A low-power input picks which code and spacing field are in use.

Top module: `pswClkDiv`

## Requirements
- R1: While `rstN` is low, `clkOut` stays low. The reset configuration is 0x0000_7F7F, so after reset the output passes exactly 128 of every 256 source pulses in either mode.
- R2: With an active code c in 0x01..0xFF and minimum spacing 0, any 256 consecutive source cycles contain exactly c+1 output pulses.
- R3: With active code 0x00, `clkOut` produces no pulses.
- R4: With minimum spacing 0, consecutive output pulses are separated by either floor(256/(c+1)) or ceil(256/(c+1)) source cycles.
- R5: Two output pulses are never closer together than m+1 source cycles. The value m comes from bits [23:16] in normal mode and from bits [31:24] in low-power mode. The value 0 means no extra limit.
- R6: Bits [7:0] of the configuration word hold the normal-mode code and bits [15:8] hold the low-power code. `lowPower` high selects the low-power code and spacing field, and `lowPower` low selects the normal ones.
- R7: A write with `wrAddr`=0 stores `wrData` in the shadow configuration only. The output rate does not change until a commit takes place.
- R8: A write with `wrAddr`=1 and `wrData`=0x0000_0032 requests a commit. Any other data value written to that address is ignored.
- R9: A requested commit copies the shadow configuration into the active one on the next accumulator carry, which comes within 256 source cycles.
- R10: `clkOut` can be high only while the source clock is high. The gate enable changes only while the source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowPower | input | 1 | Selects the low-power code and spacing field |
| wrEn | input | 1 | Write strobe for the register interface |
| wrAddr | input | 1 | 0 = shadow configuration, 1 = commit action |
| wrData | input | 32 | Write data |
| clkOut | output | 1 | Gated, time-averaged output clock |

## Verification
The assertions check four things on every cycle:
- a zero code never produces a pass decision;
- a full-rate code with no spacing limit always produces one;
- pass decisions always respect the selected minimum spacing;
- a commit becomes pending only after the correct key, and the active configuration changes only on a wrap while a commit is pending.

Some behaviours need a window of cycles and can only be shown by the bench scenarios. These are:
- the exact pulse count per 256 cycles;
- the two-valued spacing for dithered codes;
- the output holding its old rate while only the shadow copy has changed;
- the output staying low during the low half of the source clock.

// File: rtl/pswDivPkg.sv
package pswDivPkg;
  parameter int CODE_W = 8;
  parameter int CFG_W = 4 * CODE_W;
  localparam logic [CFG_W-1:0] COMMIT_KEY = CFG_W'(32'h32);
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_COMMIT = 1'b1;

  typedef struct packed {
    logic applyReq;
    logic [CFG_W-1:0] cfgWord;
  } ctrlBus_t;
endpackage

// File: rtl/pswDivCtrl.sv
module pswDivCtrl
  import pswDivPkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(32'h0000_7F7F)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CFG_W-1:0] wrData,
  input  logic             cfgTaken,
  output ctrlBus_t         ctrlBus
);
  logic [CFG_W-1:0] shadowCfg;
  logic             pending;
  logic             cfgWrite;
  logic             keyWrite;

  assign cfgWrite = wrEn && (wrAddr == ADDR_CFG);
  assign keyWrite = wrEn && (wrAddr == ADDR_COMMIT) && (wrData == COMMIT_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= RESET_CFG;
    end else if (cfgWrite) begin
      shadowCfg <= wrData;
    end
  end

  // a new key write wins over a simultaneous apply
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (keyWrite) begin
      pending <= 1'b1;
    end else if (cfgTaken) begin
      pending <= 1'b0;
    end
  end

  assign ctrlBus.applyReq = pending;
  assign ctrlBus.cfgWord  = shadowCfg;
endmodule

// File: rtl/pswDivDatapath.sv
module pswDivDatapath
  import pswDivPkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(32'h0000_7F7F)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowPower,
  input  ctrlBus_t         ctrlBus,
  output logic             cfgTaken,
  output logic [CFG_W-1:0] activeCfg,
  output logic             passQ,
  output logic             clkOut
);
  localparam int SUM_W = CODE_W + 1;
  localparam int NUM_FIELDS = 4;

  logic [CODE_W-1:0] field [NUM_FIELDS];
  logic [CODE_W-1:0] selCode;
  logic [CODE_W-1:0] selMin;
  logic [CODE_W-1:0] acc;
  logic [CODE_W-1:0] gapCnt;
  logic [SUM_W-1:0]  sum;
  logic              carry;
  logic              credit;
  logic              creditNext;
  logic              allowed;
  logic              want;
  logic              pass;
  logic              gateEn;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    assign field[g] = activeCfg[g*CODE_W +: CODE_W];
  end

  // field order: [0] normal code, [1] low-power code, [2] normal spacing, [3] low-power spacing
  assign selCode = lowPower ? field[1] : field[0];
  assign selMin  = lowPower ? field[3] : field[2];

  assign sum     = {1'b0, acc} + {1'b0, selCode} + SUM_W'(1);
  assign carry   = sum[CODE_W];
  assign allowed = (gapCnt >= selMin);
  assign want    = (carry || credit) && (selCode != '0);
  assign pass    = want && allowed;
  // at most one deferred pulse is held back by the spacing limit
  assign creditNext = (selCode != '0) &&
                      ((carry && credit) || ((carry || credit) && !pass));
  assign cfgTaken = ctrlBus.applyReq && carry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      gapCnt    <= '1;
      credit    <= 1'b0;
      passQ     <= 1'b0;
      activeCfg <= RESET_CFG;
    end else begin
      acc    <= sum[CODE_W-1:0];
      credit <= creditNext;
      passQ  <= pass;
      if (pass) begin
        gapCnt <= '0;
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + CODE_W'(1);
      end
      if (cfgTaken) begin
        activeCfg <= ctrlBus.cfgWord;
      end
    end
  end

  // enable moves only while the source clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      gateEn <= 1'b0;
    end else begin
      gateEn <= passQ;
    end
  end

  assign clkOut = clk & gateEn;
endmodule

// File: rtl/pswClkDiv.sv
module pswClkDiv
  import pswDivPkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(32'h0000_7F7F)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowPower,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CFG_W-1:0] wrData,
  output logic             clkOut
);
  ctrlBus_t         ctrlBus;
  logic             cfgTaken;
  logic [CFG_W-1:0] activeCfg;
  logic             passQ;

  pswDivCtrl #(.RESET_CFG(RESET_CFG)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgTaken(cfgTaken), .ctrlBus(ctrlBus)
  );

  pswDivDatapath #(.RESET_CFG(RESET_CFG)) uDp (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .ctrlBus(ctrlBus),
    .cfgTaken(cfgTaken), .activeCfg(activeCfg), .passQ(passQ), .clkOut(clkOut)
  );
endmodule

// File: rtl/pswClkDivChk.sv
module pswClkDivChk
  import pswDivPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             lowPower,
  input logic             wrEn,
  input logic             wrAddr,
  input logic [CFG_W-1:0] wrData,
  input logic             commitPend,
  input logic             cfgTaken,
  input logic [CFG_W-1:0] activeCfg,
  input logic             passQ
);
  logic [CODE_W-1:0] codeNow;
  logic [CODE_W-1:0] minNow;
  logic [CODE_W-1:0] sinceCnt;

  assign codeNow = lowPower ? activeCfg[2*CODE_W-1:CODE_W] : activeCfg[CODE_W-1:0];
  assign minNow  = lowPower ? activeCfg[4*CODE_W-1:3*CODE_W] : activeCfg[3*CODE_W-1:2*CODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCnt <= '1;
    end else if (passQ) begin
      sinceCnt <= '0;
    end else if (sinceCnt != '1) begin
      sinceCnt <= sinceCnt + CODE_W'(1);
    end
  end

  // R3
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeNow == '0) |=> !passQ);

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeNow == '1 && minNow == '0) |=> passQ);

  // R5
  min_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    passQ |-> (sinceCnt >= $past(minNow)));

  // R8
  commit_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitPend) |-> $past(wrEn && wrAddr == ADDR_COMMIT && wrData == COMMIT_KEY));

  // R9
  apply_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeCfg) |-> $past(cfgTaken && commitPend));
endmodule

bind pswClkDiv pswClkDivChk uChk (
  .clk(clk), .rstN(rstN), .lowPower(lowPower), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .commitPend(ctrlBus.applyReq), .cfgTaken(cfgTaken),
  .activeCfg(activeCfg), .passQ(passQ)
);

// File: tb/sim_pswClkDiv.sv
`timescale 1ns/1ps
module sim_pswClkDiv;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowPower = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic clkOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pswClkDiv u0 (.clk(clk), .rstN(rstN), .lowPower(lowPower), .wrEn(wrEn),
                .wrAddr(wrAddr), .wrData(wrData), .clkOut(clkOut));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gapLo(input int c); return 256 / (c + 1); endfunction
  function automatic int gapHi(input int c); return (256 + c) / (c + 1); endfunction

  task automatic busWrite(input logic addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // counts pulses over n source cycles; also checks R10 at each low phase
  task automatic countWindow(input int n, output int cnt, output int minG, output int maxG);
    int lastIdx;
    cnt = 0; minG = 1 << 20; maxG = 0; lastIdx = -1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (clkOut) begin
        if (lastIdx >= 0) begin
          if (i - lastIdx < minG) minG = i - lastIdx;
          if (i - lastIdx > maxG) maxG = i - lastIdx;
        end
        lastIdx = i;
        cnt++;
      end
      @(negedge clk); #1;
      if (clkOut) check(1'b0, "R10 high during low phase", 1, 0);
    end
  endtask

  task automatic applyCfg(input logic [31:0] cfg);
    busWrite(1'b0, cfg);
    busWrite(1'b1, 32'h32);
    waitCycles(300);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, minG, maxG;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    // R1 reset
    repeat (5) begin
      @(posedge clk); #1;
      check(clkOut == 1'b0, "R1 low in reset", int'(clkOut), 0);
    end
    @(negedge clk); rstN = 1'b1;
    waitCycles(10);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 128, "R1 reset rate", cnt, 128);
    lowPower = 1'b1; waitCycles(4);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 128, "R1 reset rate lp", cnt, 128);
    lowPower = 1'b0; waitCycles(4);

    // R7 shadow only
    busWrite(1'b0, 32'h0000_0303);
    waitCycles(600);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 128, "R7 shadow no effect", cnt, 128);
    // R8 wrong key ignored
    busWrite(1'b1, 32'h33);
    busWrite(1'b1, 32'h0100_0032);
    waitCycles(300);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 128, "R8 wrong key", cnt, 128);
    // R9 commit
    busWrite(1'b1, 32'h32);
    waitCycles(300);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 4, "R9 committed rate", cnt, 4);
    check(minG == 64 && maxG == 64, "R4 even spacing", minG, 64);

    // R3 zero code
    applyCfg(32'h0000_0000);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 0, "R3 stopped", cnt, 0);

    // R6 field select
    applyCfg(32'h0000_FF00);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 0, "R6 normal field", cnt, 0);
    lowPower = 1'b1; waitCycles(4);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 256, "R6 lp field", cnt, 256);
    lowPower = 1'b0; waitCycles(4);

    // R4 dithered code
    applyCfg(32'h0000_0054);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 85, "R2 dithered count", cnt, 85);
    check(minG >= gapLo(84) && maxG <= gapHi(84), "R4 dither spacing", maxG, gapHi(84));

    // R5 minimum spacing, normal and low-power fields
    applyCfg(32'h0003_00FF);
    countWindow(256, cnt, minG, maxG);
    check(cnt == 64, "R5 spacing cap count", cnt, 64);
    check(minG >= 4, "R5 spacing normal", minG, 4);
    applyCfg(32'h0500_7F00);
    lowPower = 1'b1; waitCycles(4);
    countWindow(256, cnt, minG, maxG);
    check(minG >= 6 && cnt > 0, "R5 spacing lp", minG, 6);
    lowPower = 1'b0; waitCycles(4);

    // R2 random codes in both modes
    for (int k = 0; k < 8; k++) begin
      int nm, lp, c;
      nm = int'($urandom_range(255, 1));
      lp = int'($urandom_range(255, 1));
      applyCfg({16'h0000, lp[7:0], nm[7:0]});
      lowPower = $urandom_range(1, 0);
      waitCycles(6);
      c = lowPower ? lp : nm;
      countWindow(256, cnt, minG, maxG);
      check(cnt == c + 1, "R2 random count", cnt, c + 1);
      if (cnt > 1)
        check(minG >= gapLo(c) && maxG <= gapHi(c), "R4 random spacing", minG, gapLo(c));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule